// File: doc/BRIEF.md
# Global Shutter Exposure Sequencer

This block times the integration period of a freeze-frame image array, in which every pixel starts and stops collecting charge at the same moment, and then asks the readout engine to start. A frame opens with an active-low photodetector clear pulse. An exposure window follows, counted in row periods taken from the readout timer's row tick. The frame closes with an active-low memory clear pulse, then an active-low charge-transfer pulse into the per-pixel memories, then a one-clock readout request.

Two mode inputs choose the behaviour. The start input selects free-running operation, where frames follow one another without a prompt, or triggered operation, where each frame waits in idle for a trigger pulse. The overlap input selects back-to-back operation or overlapped operation. In back-to-back operation the next exposure waits for the whole readout plus the vertical blanking. In overlapped operation the next exposure runs during the readout of the current frame. The exposure may be longer than the readout. The frame period then follows the exposure, and the blanking rows are counted from the end of the exposure.

The states are IDLE, PDRST (photodetector clear), EXPOSE, MEMRST (memory clear), XFER (charge transfer), REQ (readout request) and WAIT (gap before the next frame). The transitions are:
- IDLE to PDRST when running free or when a trigger arrives.
- PDRST to EXPOSE after PULSE_CLKS clocks.
- EXPOSE to MEMRST on the row tick that completes the exposure.
- MEMRST to XFER after PULSE_CLKS clocks.
- XFER to REQ after PULSE_CLKS clocks.
- REQ to WAIT after one clock.
- WAIT to PDRST (free-running) or to IDLE (triggered) once the gap has been counted.

Top module: `gs_expo_seq`

## Requirements
- R1: During and straight after reset, expose_o and start_rd_o are 0, and pd_rst_n_o, mem_rst_n_o and xfer_n_o are 1.
- R2: In triggered mode (snap_mode_i=1) with no trigger, the block stays idle and issues no pulse. A one-clock trigger in idle starts a frame with a pd_rst_n_o low pulse exactly PULSE_CLKS clocks long.
- R3: expose_o rises right after the photodetector clear pulse. It stays high for exactly L row ticks, where L is the clamped exposure length, and it falls straight after the L-th tick.
- R4: The exposure length L is exp_rows_i clamped to the range 2 to 256*FRAME_ROWS row periods. It is sampled when a frame starts.
- R5: After the exposure, mem_rst_n_o is low for PULSE_CLKS clocks. xfer_n_o then goes low for PULSE_CLKS clocks, beginning in the clock after the memory clear ends. The two pulses never overlap.
- R6: start_rd_o is high for exactly one clock, in the clock after xfer_n_o returns high, and once per frame.
- R7: A trigger that arrives while a frame is in progress (any state other than idle) is ignored. No second photodetector clear is issued for it.
- R8: In free-running back-to-back mode (snap_mode_i=0, seq_mode_i=1), the next photodetector clear starts after FRAME_ROWS+VB_ROWS row ticks have been counted after the readout request.
- R9: In free-running overlapped mode (seq_mode_i=0), the gap after the readout request is max(0, FRAME_ROWS-L)+VB_ROWS row ticks. When L is larger than FRAME_ROWS, only the blanking rows separate frames.
- R10: snap_mode_i is read in idle and at the end of WAIT. After a switch to triggered mode, the current frame completes and the block returns to idle. seq_mode_i and the exposure length take effect at the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Frame trigger in triggered mode |
| row_tick_i | input | 1 | One-clock pulse per row period from the readout timer |
| exp_rows_i | input | EXP_W | Requested exposure in row periods |
| snap_mode_i | input | 1 | 1 = triggered, 0 = free-running |
| seq_mode_i | input | 1 | 1 = back-to-back, 0 = overlapped |
| expose_o | output | 1 | High during integration |
| pd_rst_n_o | output | 1 | Active-low photodetector clear pulse |
| mem_rst_n_o | output | 1 | Active-low pixel memory clear pulse |
| xfer_n_o | output | 1 | Active-low charge-transfer pulse |
| start_rd_o | output | 1 | One-clock readout request |

## Verification
The bench builds the block with FRAME_ROWS=8, VB_ROWS=2 and PULSE_CLKS=3. A frame of eight rows keeps a full-length exposure of 2048 rows short enough to run, so the upper clamp can be tested. It also lets both an exposure shorter than the readout and one longer than it appear in overlapped mode. A pulse width of 3 and a blanking of 2 differ from the defaults and from each other. A width counter or gap counter that is off by one, or that uses the wrong parameter, therefore gives a measurable difference.

// File: rtl/gs_expo_pkg.sv
package gs_expo_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PDRST,
        S_EXPOSE,
        S_MEMRST,
        S_XFER,
        S_REQ,
        S_WAIT
    } seq_state_t;
endpackage

// File: rtl/gs_row_cnt.sv
module gs_row_cnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic         tick_i,
    input  logic [W-1:0] target_i,
    output logic         reach_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (clr_i)           cnt_q <= '0;
        else if (en_i && tick_i)  cnt_q <= cnt_q + 1'b1;
    end

    assign reach_o = (cnt_q == target_i);
endmodule

// File: rtl/gs_pulse_tmr.sv
module gs_pulse_tmr #(
    parameter int PULSE_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic done_o
);
    localparam int PW = (PULSE_CLKS > 1) ? $clog2(PULSE_CLKS) : 1;

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (en_i)   cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = en_i && (cnt_q == PW'(PULSE_CLKS - 1));
endmodule

// File: rtl/gs_expo_seq.sv
module gs_expo_seq
    import gs_expo_pkg::*;
#(
    parameter int FRAME_ROWS = 8,
    parameter int VB_ROWS    = 1,
    parameter int PULSE_CLKS = 2,
    parameter int EXP_W      = $clog2(256 * FRAME_ROWS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             row_tick_i,
    input  logic [EXP_W-1:0] exp_rows_i,
    input  logic             snap_mode_i,
    input  logic             seq_mode_i,
    output logic             expose_o,
    output logic             pd_rst_n_o,
    output logic             mem_rst_n_o,
    output logic             xfer_n_o,
    output logic             start_rd_o
);
    localparam logic [EXP_W-1:0] MIN_EXP  = EXP_W'(2);
    localparam logic [EXP_W-1:0] MAX_EXP  = EXP_W'(256 * FRAME_ROWS);
    localparam logic [EXP_W-1:0] READ_LEN = EXP_W'(FRAME_ROWS);
    localparam logic [EXP_W-1:0] VB_LEN   = EXP_W'(VB_ROWS);

    seq_state_t state_q, state_d;
    logic [EXP_W-1:0] exp_len_q, wait_tgt_q;
    logic [EXP_W-1:0] exp_len_d, wait_tgt_d, row_tgt;
    logic             frame_start, state_chg, pulse_state;
    logic             pulse_done, rows_reach;

    // clamp and gap target for a starting frame
    always_comb begin
        if (exp_rows_i < MIN_EXP)      exp_len_d = MIN_EXP;
        else if (exp_rows_i > MAX_EXP) exp_len_d = MAX_EXP;
        else                           exp_len_d = exp_rows_i;
        if (seq_mode_i)                wait_tgt_d = READ_LEN + VB_LEN;
        else if (exp_len_d < READ_LEN) wait_tgt_d = READ_LEN - exp_len_d + VB_LEN;
        else                           wait_tgt_d = VB_LEN;
    end

    assign state_chg   = (state_d != state_q);
    assign frame_start = (state_d == S_PDRST) && (state_q != S_PDRST);
    assign pulse_state = (state_q == S_PDRST) || (state_q == S_MEMRST) ||
                         (state_q == S_XFER);
    assign row_tgt     = (state_q == S_EXPOSE) ? (exp_len_q - 1'b1) : wait_tgt_q;

    gs_pulse_tmr #(.PULSE_CLKS(PULSE_CLKS)) pulse_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (state_chg),
        .en_i   (pulse_state),
        .done_o (pulse_done)
    );

    gs_row_cnt #(.W(EXP_W)) rows_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (state_chg),
        .en_i     ((state_q == S_EXPOSE) || (state_q == S_WAIT)),
        .tick_i   (row_tick_i),
        .target_i (row_tgt),
        .reach_o  (rows_reach)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (!snap_mode_i || trig_i)     state_d = S_PDRST;
            S_PDRST:  if (pulse_done)                 state_d = S_EXPOSE;
            S_EXPOSE: if (row_tick_i && rows_reach)   state_d = S_MEMRST;
            S_MEMRST: if (pulse_done)                 state_d = S_XFER;
            S_XFER:   if (pulse_done)                 state_d = S_REQ;
            S_REQ:                                    state_d = S_WAIT;
            S_WAIT:   if (rows_reach) state_d = snap_mode_i ? S_IDLE : S_PDRST;
            default:                                  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            exp_len_q  <= MIN_EXP;
            wait_tgt_q <= VB_LEN;
        end else begin
            state_q <= state_d;
            if (frame_start) begin
                exp_len_q  <= exp_len_d;
                wait_tgt_q <= wait_tgt_d;
            end
        end
    end

    always_comb begin
        expose_o    = (state_q == S_EXPOSE);
        pd_rst_n_o  = (state_q != S_PDRST);
        mem_rst_n_o = (state_q != S_MEMRST);
        xfer_n_o    = (state_q != S_XFER);
        start_rd_o  = (state_q == S_REQ);
    end

    // R3
    expose_end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(expose_o) |-> $past(row_tick_i));
    // R5
    xfer_after_memclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_n_o) |-> $past(!mem_rst_n_o));
    // R6
    req_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_n_o) |-> start_rd_o);
    // R6
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_rd_o |=> !start_rd_o);
    // R7
    clear_only_from_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_rst_n_o) |-> $past(state_q == S_IDLE || state_q == S_WAIT));
    // R5
    pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!pd_rst_n_o, !mem_rst_n_o, !xfer_n_o, expose_o}) <= 1);
endmodule

// File: tb/gs_expo_seq_tb_top.sv
module gs_expo_seq_tb_top;
    localparam int FR = 8;
    localparam int VB = 2;
    localparam int PC = 3;
    localparam int EW = $clog2(256 * FR) + 1;

    logic clk = 0, rst_n = 0, trig = 0, tick = 0, snap = 1, seqm = 1;
    logic [EW-1:0] exp_rows = 3;
    logic expose, pd_n, mem_n, xf_n, rd;

    int tests = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gs_expo_seq #(.FRAME_ROWS(FR), .VB_ROWS(VB), .PULSE_CLKS(PC)) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .row_tick_i(tick),
        .exp_rows_i(exp_rows), .snap_mode_i(snap), .seq_mode_i(seqm),
        .expose_o(expose), .pd_rst_n_o(pd_n), .mem_rst_n_o(mem_n),
        .xfer_n_o(xf_n), .start_rd_o(rd));

    // monitor
    int cyc = 0, pd_falls, pd_low, mem_low, xf_low, exp_ticks, rd_cnt;
    int mem_fall, xf_fall, xf_last, rd_cyc, gap_ticks, gap_res;
    bit in_gap, gap_valid, pd_p = 1, mem_p = 1, xf_p = 1;

    task automatic clear_mon();
        pd_falls = 0; pd_low = 0; mem_low = 0; xf_low = 0; exp_ticks = 0;
        rd_cnt = 0; mem_fall = -1; xf_fall = -1; xf_last = -1; rd_cyc = -1;
        gap_ticks = 0; gap_res = -1; in_gap = 0; gap_valid = 0;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!pd_n && pd_p) begin
            pd_falls++;
            if (in_gap) begin gap_res = gap_ticks; gap_valid = 1; in_gap = 0; end
        end else if (in_gap && tick) gap_ticks++;
        if (!pd_n) pd_low++;
        if (expose && tick) exp_ticks++;
        if (!mem_n) begin mem_low++; if (mem_p) mem_fall = cyc; end
        if (!xf_n) begin xf_low++; if (xf_p) xf_fall = cyc; xf_last = cyc; end
        if (rd) begin rd_cnt++; rd_cyc = cyc; in_gap = 1; gap_ticks = 0; end
        pd_p = pd_n; mem_p = mem_n; xf_p = xf_n;
    end

    // row tick: one clock high every five
    initial begin
        forever begin
            repeat (4) @(posedge clk);
            #1 tick = 1;
            @(posedge clk);
            #1 tick = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_trig();
        @(posedge clk); #1 trig = 1;
        @(posedge clk); #1 trig = 0;
    endtask

    task automatic wait_rd(input int n);
        while (rd_cnt < n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 expose", int'(expose), 0);
        chk("R1 pulses", int'({pd_n, mem_n, xf_n}), 7);
        chk("R1 start_rd", int'(rd), 0);
    endtask

    task automatic t_idle_quiet();
        clear_mon();
        repeat (100) @(negedge clk);
        chk("R2 no trigger no frame", pd_falls, 0);
    endtask

    task automatic t_snap(input int req_rows, input int exp_len, input bit retrig, input string tag);
        clear_mon();
        exp_rows = EW'(req_rows);
        seqm = 1;
        pulse_trig();
        if (retrig) begin
            while (!expose) @(negedge clk);
            repeat (3) @(negedge clk);
            pulse_trig();
        end
        wait_rd(1);
        repeat (300) @(negedge clk);
        chk({tag, " R7/R2 one clear"}, pd_falls, 1);
        chk({tag, " R2 clear width"}, pd_low, PC);
        chk({tag, " R3/R4 exposure ticks"}, exp_ticks, exp_len);
        chk({tag, " R5 memclr width"}, mem_low, PC);
        chk({tag, " R5 xfer width"}, xf_low, PC);
        chk({tag, " R5 order"}, xf_fall - mem_fall, PC);
        chk({tag, " R6 request timing"}, rd_cyc - xf_last, 1);
        chk({tag, " R6 request count"}, rd_cnt, 1);
    endtask

    task automatic t_master(input int req_rows, input bit sq, input int gap, input string tag);
        clear_mon();
        exp_rows = EW'(req_rows);
        seqm = sq;
        @(posedge clk); #1 snap = 0;
        while (!gap_valid) @(negedge clk);
        #1 snap = 1;
        chk({tag, " gap ticks"}, gap_res, gap);
        wait_rd(2);
        repeat (300) @(negedge clk);
        chk({tag, " R10 back to idle"}, pd_falls, 2);
        chk({tag, " R3 exposure ticks both frames"}, exp_ticks, 2 * req_rows);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1;
        repeat (3) @(negedge clk);
        t_reset();
        t_idle_quiet();
        t_snap(3, 3, 0, "snap exp3");
        t_snap(0, 2, 0, "R4 low clamp 0");
        t_snap(1, 2, 0, "R4 low clamp 1");
        t_snap(6, 6, 1, "R7 retrigger");
        t_snap(4095, 256 * FR, 0, "R4 high clamp");
        t_master(3, 1, FR + VB, "R8 seq");
        t_master(3, 0, FR - 3 + VB, "R9 overlap short");
        t_master(20, 0, VB, "R9 overlap long");
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule